// File: doc/BRIEF.md
# SD Command Token Transmitter

This block sends one 48-bit SD/MMC command token on the card's CMD line. Software stages the token in three 16-bit registers and then writes a fire word. The block loads the token into a shift register and drives it out most significant bit first, one bit on each card clock enable pulse. While it shifts, it works out the CRC7 over the first 40 bits. When the token has gone out, it compares that CRC with the CRC byte that software supplied.

The fire word carries a request toggle bit. The block copies this bit into the status word when the command completes, so software can tell which command a completion belongs to. While a command is still in progress, a new fire write is refused and a reject flag is raised. A deselect command (index 7, argument 0) gets no response, so the block goes back to idle straight after the end bit. Any other command holds the busy state for a short, parameterised response turnaround window first.

Top module: `sd_cmd_tx`

## Requirements
- R1: After reset, `cmd_out` is 1 and `status` reads 16'h0001: idle set, every flag clear, echo bit 0.
- R2: The token goes out MSB first in this order: bits 15..0 of the high word (address 2), then the middle word (address 1), then the low word (address 0). Byte 0 (0x40 OR the 6-bit index) is the high byte of the high word. The argument runs from the low byte of the high word through the high byte of the low word, most significant byte first. The CRC byte is the low byte of the low word.
- R3: `cmd_out` changes only on a cycle in which `clk_en` is high, and each `clk_en` pulse while shifting moves exactly one token bit onto the line.
- R4: `cmd_out` is 1 whenever the block is idle. It is also 1 between an accepted fire and the first `clk_en` pulse.
- R5: Idle (`status[0]`) falls on the cycle after an accepted fire. For a command that is not a deselect, idle rises on the clock edge of the (49 + NCR_CYCLES)-th `clk_en` pulse counted from the fire. Idle never rises on a cycle without `clk_en`.
- R6: A deselect command (index 7, argument 0) returns to idle on the edge of the 49th `clk_en` pulse, the one after the end bit was driven.
- R7: Bit 12 of the fire word is the request toggle. It is copied to `status[15]` when the accepted command completes. `status[15]` does not change while the block is busy.
- R8: A fire write (`wr_addr` 3) while the block is not idle is ignored: the token in flight and its toggle are unaffected, and `status[1]` is set. `status[1]` clears on the next accepted fire. This holds even when the fire write lands in the same cycle as the completing `clk_en` pulse.
- R9: At completion, `status[2]` is set if bits 7..1 of the CRC byte differ from the CRC7 (x^7+x^3+1, initial value 0) of the first 40 token bits, or if bit 0 of the CRC byte is 0. `status[2]` clears on the next accepted fire.
- R10: Writes to the token registers while a command is being sent do not alter the bits on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 low token word, 1 middle word, 2 high word, 3 fire word |
| wr_data | input | 16 | Write data; in the fire word, bit 12 is the request toggle |
| clk_en | input | 1 | Card clock enable; one line bit per pulse |
| cmd_out | output | 1 | CMD line output |
| status | output | 16 | Bit 0 idle, bit 1 reject, bit 2 CRC error, bit 15 toggle echo |

## Verification
Two things can happen in the same cycle here: a fire write, and the `clk_en` pulse that completes the command in flight. Because the write sees a busy block at that edge, it must be refused, even though idle rises on that same edge. The bench provokes this by placing the fire write, with the opposite toggle, on exactly the completing pulse. It then checks that the reject flag is set, idle is high, the echo carries the old toggle, and the line stays high. The same overlap is also exercised mid-token, and with a token-register write landing on a shifting pulse.

// File: rtl/sd_cmd_tx_pkg.sv
package sd_cmd_tx_pkg;
  localparam int WORD_W     = 16;
  localparam int TOKEN_BITS = 48;
  localparam int CRC_SPAN   = 40;
  localparam int CRC_W      = 7;

  localparam logic [1:0] ADDR_TOK_LO  = 2'd0;
  localparam logic [1:0] ADDR_TOK_MID = 2'd1;
  localparam logic [1:0] ADDR_TOK_HI  = 2'd2;
  localparam logic [1:0] ADDR_FIRE    = 2'd3;

  localparam int FIRE_TOGGLE_BIT = 12;
  localparam int STAT_IDLE    = 0;
  localparam int STAT_REJECT  = 1;
  localparam int STAT_CRC_ERR = 2;
  localparam int STAT_ECHO    = 15;

  localparam logic [5:0] DESELECT_INDEX = 6'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL, ST_WAIT} tx_state_t;

  // One serial CRC7 step, generator x^7 + x^3 + 1
  function automatic logic [CRC_W-1:0] crc7_next(input logic [CRC_W-1:0] crc, input logic din);
    logic fb;
    fb = din ^ crc[CRC_W-1];
    crc7_next = {crc[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  // Index 7 with a zero argument: no response follows
  function automatic logic is_deselect(input logic [TOKEN_BITS-1:0] tok);
    is_deselect = (tok[45:40] == DESELECT_INDEX) && (tok[39:8] == 32'd0);
  endfunction

  // CRC byte matches the computed value and carries the end bit
  function automatic logic tail_ok(input logic [7:0] tail, input logic [CRC_W-1:0] crc);
    tail_ok = (tail[7:1] == crc) && tail[0];
  endfunction
endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7
  import sd_cmd_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '0;
    else if (clear) crc <= '0;
    else if (step)  crc <= crc7_next(crc, din);
  end
endmodule

// File: rtl/sd_cmd_shifter.sv
module sd_cmd_shifter #(
  parameter int BITS = 48,
  parameter int SPAN = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] token,
  input  logic            tick,
  output logic            bit_now,
  output logic            last,
  output logic            in_span
);
  localparam int CW = $clog2(BITS + 1);

  logic [BITS-1:0] sr;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (load) begin
      sr  <= token;
      cnt <= '0;
    end else if (tick) begin
      sr  <= {sr[BITS-2:0], 1'b0};
      cnt <= cnt + 1'b1;
    end
  end

  assign bit_now = sr[BITS-1];
  assign last    = (cnt == CW'(BITS - 1));
  assign in_span = (cnt < CW'(SPAN));
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_tx_pkg::*;
#(
  parameter int NCR_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              clk_en,
  output logic              cmd_out,
  output logic [WORD_W-1:0] status
);
  localparam int WCNT_W = (NCR_CYCLES > 1) ? $clog2(NCR_CYCLES) : 1;

  tx_state_t         state;
  logic [WORD_W-1:0] tok_lo, tok_mid, tok_hi;
  logic [7:0]        tail_q;
  logic              desel_q, tog_q, echo_q, rej_q, crc_err_q, cmd_q;
  logic [WCNT_W-1:0] wcnt;

  // Named internal events
  logic fire_wr, fire_accept, fire_reject, bit_tick, tail_tick, cmd_finish;
  logic bit_now, shift_last, in_span;
  logic [CRC_W-1:0] crc_val;
  logic [TOKEN_BITS-1:0] staged;

  assign staged      = {tok_hi, tok_mid, tok_lo};
  assign fire_wr     = wr_en && (wr_addr == ADDR_FIRE);
  assign fire_accept = fire_wr && (state == ST_IDLE);
  assign fire_reject = fire_wr && (state != ST_IDLE);
  assign bit_tick    = clk_en && (state == ST_SHIFT);
  assign tail_tick   = clk_en && (state == ST_TAIL);
  assign cmd_finish  = (tail_tick && desel_q) ||
                       (clk_en && (state == ST_WAIT) && (wcnt == WCNT_W'(NCR_CYCLES - 1)));

  sd_cmd_shifter #(.BITS(TOKEN_BITS), .SPAN(CRC_SPAN)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(fire_accept), .token(staged),
    .tick(bit_tick), .bit_now(bit_now), .last(shift_last), .in_span(in_span)
  );

  sd_cmd_crc7 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(fire_accept),
    .step(bit_tick && in_span), .din(bit_now), .crc(crc_val)
  );

  // Staging registers, free to change while a token is in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_lo <= '0; tok_mid <= '0; tok_hi <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_TOK_LO:  tok_lo  <= wr_data;
        ADDR_TOK_MID: tok_mid <= wr_data;
        ADDR_TOK_HI:  tok_hi  <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; wcnt <= '0; cmd_q <= 1'b1;
      tail_q <= '0; desel_q <= 1'b0; tog_q <= 1'b0;
      echo_q <= 1'b0; rej_q <= 1'b0; crc_err_q <= 1'b0;
    end else begin
      if (fire_accept) begin
        state     <= ST_SHIFT;
        tail_q    <= tok_lo[7:0];
        desel_q   <= is_deselect(staged);
        tog_q     <= wr_data[FIRE_TOGGLE_BIT];
        rej_q     <= 1'b0;
        crc_err_q <= 1'b0;
      end
      if (fire_reject) rej_q <= 1'b1;
      if (bit_tick) begin
        cmd_q <= bit_now;
        if (shift_last) state <= ST_TAIL;
      end
      if (tail_tick) begin
        cmd_q <= 1'b1;
        wcnt  <= '0;
        if (!desel_q) state <= ST_WAIT;
      end
      if (clk_en && (state == ST_WAIT)) wcnt <= wcnt + 1'b1;
      if (cmd_finish) begin
        state     <= ST_IDLE;
        echo_q    <= tog_q;
        crc_err_q <= !tail_ok(tail_q, crc_val);
      end
    end
  end

  assign cmd_out = cmd_q;

  always_comb begin
    status               = '0;
    status[STAT_IDLE]    = (state == ST_IDLE);
    status[STAT_REJECT]  = rej_q;
    status[STAT_CRC_ERR] = crc_err_q;
    status[STAT_ECHO]    = echo_q;
  end
endmodule

// File: rtl/sd_cmd_tx_checker.sv
module sd_cmd_tx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        clk_en,
  input logic        cmd_out,
  input logic [15:0] status,
  input logic        fire_wr,
  input logic        fire_accept,
  input logic        cmd_finish
);
  assert_line_high_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> cmd_out);

  assert_line_on_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(cmd_out));

  assert_idle_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_accept |=> !status[0]);

  assert_idle_waits_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[0] && !clk_en) |=> !status[0]);

  assert_busy_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_wr && !status[0]) |=> status[1]);

  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_accept |=> (!status[1] && !status[2]));

  assert_echo_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[0] && !cmd_finish) |=> $stable(status[15]));
endmodule

bind sd_cmd_tx sd_cmd_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cmd_out(cmd_out), .status(status),
  .fire_wr(fire_wr), .fire_accept(fire_accept), .cmd_finish(cmd_finish)
);

// File: tb/sd_cmd_tx_bench.sv
module sd_cmd_tx_bench;
  localparam int NCR = 2;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, clk_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic cmd_out;
  logic [15:0] status;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sd_cmd_tx #(.NCR_CYCLES(NCR)) u_sd_cmd_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clk_en(clk_en), .cmd_out(cmd_out), .status(status)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] bits);
    logic [6:0] c = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      logic top = c[6];
      c = {c[5:0], 1'b0};
      if (top != bits[i]) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic w, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); clk_en = 1'b1; wr_en = w; wr_addr = a; wr_data = d;
    @(negedge clk); clk_en = 1'b0; wr_en = 1'b0;
  endtask

  // tail_mode: 0 good, 1 CRC flipped, 2 end bit cleared
  task automatic run_cmd(input string name, input logic [5:0] idx, input logic [31:0] arg,
                         input int tail_mode, input logic tog, input int reject_at, input int stage_at);
    logic [39:0] head;
    logic [7:0] tail;
    logic [47:0] tok;
    int bit_err = 0, stab_err = 0, finish_at = 0, exp_fin;
    head = {2'b01, idx, arg};
    tail = {ref_crc(head), 1'b1};
    if (tail_mode == 1) tail = tail ^ 8'h02;
    if (tail_mode == 2) tail = tail ^ 8'h01;
    tok = {head, tail};
    exp_fin = (idx == 6'd7 && arg == 32'd0) ? 49 : 49 + NCR;
    wr(2'd0, tok[15:0]); wr(2'd1, tok[31:16]); wr(2'd2, tok[47:32]);
    wr(2'd3, {3'b000, tog, 12'h000});
    chk("R5", {name, " idle low after fire"}, status[0], 1'b0);
    chk("R8", {name, " reject and crc flags cleared by fire"}, status[2:1], 2'b00);
    chk("R4", {name, " line high before first pulse"}, cmd_out, 1'b1);
    for (int i = 1; i <= 80; i++) begin
      logic held;
      if (i == reject_at)     pulse(1'b1, 2'd3, {3'b000, ~tog, 12'h000});
      else if (i == stage_at) pulse(1'b1, 2'd0, ~tok[15:0]);
      else                    pulse(1'b0, 2'd0, 16'h0);
      if (i <= 48 && cmd_out !== tok[48-i]) bit_err++;
      if (status[0]) begin finish_at = i; break; end
      held = cmd_out;
      repeat (i % 3) begin
        @(negedge clk);
        if (cmd_out !== held) stab_err++;
      end
    end
    chk("R2", {name, " token bit mismatches"}, bit_err, 0);
    chk("R3", {name, " line moves without clk_en"}, stab_err, 0);
    if (stage_at > 0) chk("R10", {name, " staging write kept off line"}, bit_err, 0);
    if (exp_fin == 49) chk("R6", {name, " deselect finish pulse"}, finish_at, exp_fin);
    else               chk("R5", {name, " finish pulse"}, finish_at, exp_fin);
    chk("R7", {name, " toggle echo"}, status[15], tog);
    chk("R9", {name, " crc error flag"}, status[2], tail_mode != 0);
    chk("R8", {name, " reject flag"}, status[1], reject_at > 0);
    chk("R4", {name, " line high after finish"}, cmd_out, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1", "reset status", status, 16'h0001);
    chk("R1", "reset line", cmd_out, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_cmd("cmd0",      6'd0,  32'h0,        0, 1'b1, 0,  0);
    run_cmd("cmd17",     6'd17, 32'h1234ABCD, 0, 1'b0, 0,  20);
    run_cmd("badcrc",    6'd8,  32'h000001AA, 1, 1'b1, 0,  0);
    run_cmd("goodafter", 6'd8,  32'h000001AA, 0, 1'b0, 0,  0);
    run_cmd("badend",    6'd55, 32'hFFFFFFFF, 2, 1'b1, 0,  0);
    run_cmd("deselect",  6'd7,  32'h0,        0, 1'b0, 0,  0);
    run_cmd("select",    6'd7,  32'h00010000, 0, 1'b1, 0,  0);
    run_cmd("midreject", 6'd24, 32'hA5A5F00F, 0, 1'b0, 10, 0);
    run_cmd("collide",   6'd13, 32'h00020000, 0, 1'b1, 49 + NCR, 0);
    run_cmd("clear",     6'd1,  32'h40FF8000, 0, 1'b0, 0,  0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule